// File: doc/BRIEF.md
# Two-Phase Stepper Winding Sequencer

This block drives the four winding lines of a two-phase stepper motor. It uses a drive scheme that keeps two neighbouring windings on at all times, one from the A pair and one from the B pair. Each step moves the energised pair round by one position. A programmable dwell count, given in clock cycles, sets the time between steps. The sequence wraps after the fourth pattern, so the rotor turns for as long as the block stays enabled.

Software or a motion controller sets the step period and the direction, then raises the enable input. The winding nibble goes to the power stage. The step strobe marks each cycle in which a new pattern first appears on the winding lines, so logic downstream can count position without decoding the nibble. Dropping the enable input freezes the rotor on its present pattern and restarts the dwell count.

Top module: `stepper_phase_seq`

## Requirements
- R1: `coils` is ordered A1 (bit 3), A2 (bit 2), B1 (bit 1), B2 (bit 0). It always holds one of 4'h9, 4'h5, 4'h6 or 4'hA, so exactly one winding of the A pair and exactly one winding of the B pair is on.
- R2: With `dir_cw` low (anticlockwise), each step moves the pattern 9h to 5h, 5h to 6h, 6h to Ah, and Ah back to 9h.
- R3: With `dir_cw` high (clockwise), each step moves the pattern Ah to 6h, 6h to 5h, 5h to 9h, and 9h back to Ah.
- R4: While `enable` stays high, the pattern changes on the P-th rising edge counted from the first edge at which `enable` is sampled high, and then again every P edges. P is the value on `period`.
- R5: A `period` of 0 acts like 1, so the pattern changes on every enabled edge.
- R6: `dir_cw` is sampled only on the edge that performs a step. A direction change moves on from the current pattern and does not restart the sequence.
- R7: While `enable` is low, the pattern holds and the dwell count returns to zero. After `enable` rises again, a full P edges pass before the next step.
- R8: `step_stb` is high for exactly those cycles in which `coils` shows a pattern different from the one in the cycle before, and low in all other cycles.
- R9: While `rst_n` is low, `coils` reads 9h and `step_stb` reads 0. Reset takes effect at once. Its release passes through two clock stages before it reaches the logic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run when high, hold the pattern when low |
| dir_cw | input | 1 | 1 = clockwise, 0 = anticlockwise |
| period | input | 16 | Dwell between steps in clock cycles (0 acts like 1) |
| coils | output | 4 | Winding drive {A1, A2, B1, B2} |
| step_stb | output | 1 | One-cycle pulse with each new pattern |

## Verification
A corrupted phase index shows up on `coils` in the cycle after the faulty edge, either as an out-of-order pattern or as an illegal nibble. Every pattern the bench samples is therefore compared with its own model of the two rotation tables. A dwell counter that misses its clear or its terminal value shifts the step edge by one or more cycles. The bench catches this by checking that the pattern has not moved on each edge before the P-th, and that it has moved on the P-th. Strobe faults are visible in the same cycle as the pattern update they should mark.

// File: rtl/stepper_pkg.sv
package stepper_pkg;

  localparam int PHASE_COUNT = 4;
  localparam int PHASE_W     = $clog2(PHASE_COUNT);

  typedef logic [PHASE_W-1:0] phase_t;
  typedef logic [3:0]         coil_t;

  // Position 0 is the reset pattern; anticlockwise walks upward.
  function automatic coil_t phase_to_coils(input phase_t p);
    coil_t c;
    case (p)
      2'd0:    c = 4'h9;
      2'd1:    c = 4'h5;
      2'd2:    c = 4'h6;
      default: c = 4'hA;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/step_timer.sv
module step_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CNT_W-1:0] period,
  output logic             tick
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last_cnt;

  // Zero period is handled as a period of one.
  assign last_cnt = (period == '0) ? '0 : period - 1'b1;
  // >= copes with a period lowered below the running count.
  assign tick     = enable && (cnt_q >= last_cnt);

  always_comb begin
    cnt_d = cnt_q;
    if (!enable)   cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (cnt_q == '0)); // R7

endmodule

// File: rtl/phase_ring.sv
module phase_ring
  import stepper_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  advance,
  input  logic  dir_cw,
  output coil_t coils,
  output logic  stb
);

  phase_t idx_q, idx_d;
  coil_t  coil_q, coil_d;
  logic   stb_q;

  always_comb begin
    idx_d = idx_q;
    if (advance) begin
      if (dir_cw) idx_d = idx_q - 1'b1;
      else        idx_d = idx_q + 1'b1;
    end
    coil_d = phase_to_coils(idx_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      coil_q <= 4'h9;
      stb_q  <= 1'b0;
    end else begin
      stb_q <= advance;
      if (advance) begin
        idx_q  <= idx_d;
        coil_q <= coil_d;
      end
    end
  end

  assign coils = coil_q;
  assign stb   = stb_q;

  AST_IDX_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (idx_q != $past(idx_q))); // R2

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(coil_q)); // R7

endmodule

// File: rtl/stepper_phase_seq.sv
module stepper_phase_seq
  import stepper_pkg::*;
#(
  parameter int PERIOD_W    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                dir_cw,
  input  logic [PERIOD_W-1:0] period,
  output logic [3:0]          coils,
  output logic                step_stb
);

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_core_n;
  logic                   step_now;
  coil_t                  coil_w;

  // Assert at once, release through a short flop chain.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_pipe[SYNC_STAGES-1];

  step_timer #(.CNT_W(PERIOD_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .enable (enable),
    .period (period),
    .tick   (step_now)
  );

  phase_ring u_ring (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .advance (step_now),
    .dir_cw  (dir_cw),
    .coils   (coil_w),
    .stb     (step_stb)
  );

  assign coils = coil_w;

  AST_TWO_ADJ: assert property (@(posedge clk) disable iff (!rst_n)
    (coils[3] ^ coils[2]) && (coils[1] ^ coils[0])); // R1

  AST_STB_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (coils != $past(coils)) |-> step_stb); // R8

  AST_CW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_stb && $past(dir_cw) && $past(coils) == 4'h9) |-> (coils == 4'hA)); // R3

  AST_CCW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_stb && !$past(dir_cw) && $past(coils) == 4'hA) |-> (coils == 4'h9)); // R2

endmodule

// File: tb/stepper_phase_seq_tb.sv
module stepper_phase_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 9;

  // {dir_cw, period[15:0], expected coils}
  localparam logic [20:0] VEC [NVEC] = '{
    {1'b0, 16'd3, 4'h5},   // R2
    {1'b0, 16'd1, 4'h6},   // R2, R4
    {1'b0, 16'd0, 4'hA},   // R5
    {1'b0, 16'd2, 4'h9},   // R2 wrap
    {1'b1, 16'd2, 4'hA},   // R3, R6 reversal
    {1'b1, 16'd4, 4'h6},   // R3
    {1'b1, 16'd1, 4'h5},   // R3
    {1'b1, 16'd3, 4'h9},   // R3
    {1'b0, 16'd2, 4'h5}    // R6
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable;
  logic        dir_cw;
  logic [15:0] period;
  logic [3:0]  coils;
  logic        step_stb;

  int checks   = 0;
  int failures = 0;

  stepper_phase_seq u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .dir_cw   (dir_cw),
    .period   (period),
    .coils    (coils),
    .step_stb (step_stb)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [3:0] next_pat(input logic [3:0] p, input logic cw);
    logic [3:0] n;
    case (p)
      4'h9:    n = cw ? 4'hA : 4'h5;
      4'h5:    n = cw ? 4'h9 : 4'h6;
      4'h6:    n = cw ? 4'h5 : 4'hA;
      default: n = cw ? 4'h6 : 4'h9;
    endcase
    return n;
  endfunction

  task automatic check(input string req, input logic [3:0] exp_c, input logic exp_s);
    checks++;
    if (coils !== exp_c || step_stb !== exp_s) begin
      failures++;
      $display("FAIL %s coils=%h stb=%b expected coils=%h stb=%b", req, coils, step_stb, exp_c, exp_s);
    end
    checks++;
    if (!((coils[3] ^ coils[2]) && (coils[1] ^ coils[0]))) begin
      failures++;
      $display("FAIL R1 coils=%h expected one of 9/5/6/A", coils);
    end
  endtask

  task automatic tick_cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [3:0] cur;
    rst_n = 1'b0; enable = 1'b0; dir_cw = 1'b0; period = 16'd1;
    repeat (2) tick_cycle();
    check("R9 reset", 4'h9, 1'b0);
    rst_n = 1'b1;
    repeat (4) tick_cycle();
    check("R7 idle hold", 4'h9, 1'b0);
    cur = 4'h9;

    // Table walk: each vector steps once from a cleared count.
    for (int i = 0; i < NVEC; i++) begin
      int eff;
      dir_cw = VEC[i][20];
      period = VEC[i][19:4];
      eff    = (VEC[i][19:4] == 0) ? 1 : int'(VEC[i][19:4]);
      enable = 1'b1;
      for (int k = 1; k < eff; k++) begin
        tick_cycle();
        check("R4 before step", cur, 1'b0);
      end
      tick_cycle();
      check("R2/R3/R8 step", VEC[i][3:0], 1'b1);
      cur    = VEC[i][3:0];
      enable = 1'b0;
      tick_cycle();
      check("R7 hold/R8 strobe low", cur, 1'b0);
    end

    // Continuous run, period 2, anticlockwise (R4, R8).
    dir_cw = 1'b0; period = 16'd2; enable = 1'b1;
    for (int i = 1; i <= 8; i++) begin
      tick_cycle();
      if (i % 2 == 0) begin
        cur = next_pat(cur, 1'b0);
        check("R4 run step", cur, 1'b1);
      end else begin
        check("R8 run gap", cur, 1'b0);
      end
    end
    enable = 1'b0;
    tick_cycle();

    // Enable drop clears the dwell count (R7).
    period = 16'd5; enable = 1'b1;
    repeat (3) tick_cycle();
    enable = 1'b0;
    repeat (2) tick_cycle();
    check("R7 paused", cur, 1'b0);
    enable = 1'b1;
    for (int k = 1; k < 5; k++) begin
      tick_cycle();
      check("R7 count restarted", cur, 1'b0);
    end
    tick_cycle();
    cur = next_pat(cur, 1'b0);
    check("R7 full period after resume", cur, 1'b1);

    // Direction flip between steps (R6).
    period = 16'd3;
    tick_cycle();
    dir_cw = 1'b1;
    tick_cycle();
    check("R6 no step yet", cur, 1'b0);
    tick_cycle();
    cur = next_pat(cur, 1'b1);
    check("R6 reverse from current", cur, 1'b1);

    // Reset while running (R9).
    period = 16'd1;
    tick_cycle();
    rst_n = 1'b0;
    #1;
    check("R9 async reset", 4'h9, 1'b0);
    tick_cycle();
    rst_n = 1'b1;
    enable = 1'b0;
    repeat (3) tick_cycle();
    check("R9 after release", 4'h9, 1'b0);

    finish_run();
  end

endmodule